// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a clocked requester and an external asynchronous static RAM of 256K bytes. The requester offers one read or one write at a time, with an address, write data and a valid/ready handshake. The block turns each request into active-low select, write and read-enable strobes, an 18-bit address and an 8-bit data bus. The bus is split into an outgoing value, an incoming value and a driver enable for the pad's tri-state buffer. A read returns its byte through a one-cycle response pulse.

Every window the memory needs is a whole number of clock cycles. Each one is computed at elaboration as the ceiling of a minimum memory time divided by the clock period parameter, and is never less than one cycle. During a write the read-enable stays high, so the shorter write pulse applies. The data driver switches on only once the memory's outputs are off. Between accesses the memory is deselected and the bus is released. Before the next access the memory rests for at least one read-cycle time. A build-time variant keeps read-enable low through writes. It lengthens the pulse to the longer minimum and delays the driver until the memory's outputs have turned off.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is applied and on the first cycle after it, the select, write and read-enable strobes are high, the driver enable and response valid are low, and ready is low. Ready first rises RC cycles after reset is released, where RC = ceil(read-cycle time / clock period), which is 3 at the default 4 ns clock.
- R2: Whenever select is high, the write and read-enable strobes are high and the driver enable is low.
- R3: A read holds select and read-enable low and write high for exactly RD cycles. RD is the largest of the ceiling-divided read-cycle, address-access and read-enable-access times, which is 3 by default.
- R4: The byte on the incoming bus in the last read cycle becomes the response data, with response valid high for exactly one cycle. Counted from the accepting clock edge, that cycle begins RD edges later.
- R5: A write starts with one setup cycle in which select is low and both the write and read-enable strobes are high. Write is then low for exactly WP cycles, the largest of the ceiling-divided write-pulse, address-to-end and data-setup times (2 by default). Write is never low while select is high.
- R6: The driver enable never rises unless read-enable was high or write was low on the previous cycle. It is never high while the memory is selected for reading (select low, read-enable low, write high).
- R7: Address and outgoing data stay constant for as long as select stays low. A byte written to any address reads back unchanged from that address.
- R8: After write rises, the data stays driven for one hold cycle with select low. Select stays low for 1 + WP + HOLD cycles, where HOLD = max(1, WC - WP - 1) and WC = ceil(write-cycle time / clock period). The driver is on during the last cycle of the write pulse.
- R9: Select stays high for at least RC cycles between two accesses.
- R10: Ready is low from the accepting edge until RC cycles after select rises, and a request held valid in that time is not taken. After a read, ready returns RD + RC edges after acceptance. After a write, it returns 1 + WP + HOLD + RC edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request may be taken this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Byte address |
| reqWdata | input | 8 | Write data |
| rspValid | output | 1 | One-cycle pulse with read data |
| rspRdata | output | 8 | Captured read byte |
| sramAddr | output | 18 | Address to memory |
| sramCeN | output | 1 | Active-low select |
| sramWeN | output | 1 | Active-low write strobe |
| sramOeN | output | 1 | Active-low read enable |
| sramDqOut | output | 8 | Outgoing data for the pad driver |
| sramDqOe | output | 1 | Pad driver enable |
| sramDqIn | input | 8 | Incoming data from the pad |

## Verification
Some properties are checked on every cycle: bus release while deselected, no driving against a reading memory, driver start only after read-enable is high, address and data held steady across an access, the exact write-pulse length, the recovery gap, and the single-cycle response. Other behaviour shows only in the bench's scenarios: exact read-window and write-window lengths, handshake latency, the byte that is captured, and correct storage across a sweep of addresses and data values, which is checked against a behavioural memory model.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  // Registered pin strobes handed from the sequencer to the datapath.
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic drive;
  } strobe_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_WSETUP,
    PH_WPULSE,
    PH_WHOLD
  } phase_e;

  // Whole clock cycles covering a time in picoseconds, never below one.
  function automatic int unsigned cyclesFor(input int unsigned timePs,
                                            input int unsigned clkPs);
    int unsigned q;
    q = (timePs + clkPs - 1) / clkPs;
    return (q == 0) ? 1 : q;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    return max2(max2(a, b), c);
  endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC    = 3,
  parameter int unsigned WP_CYC    = 2,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned RC_CYC    = 3,
  parameter int unsigned DRV_DLY   = 0,
  parameter bit          OE_LOW_WR = 1'b0,
  parameter int unsigned CNT_W     = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    accept,
  output logic    capture,
  output logic    rspValid,
  output strobe_t strobes
);

  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RC_LOAD   = CNT_W'(RC_CYC);
  localparam logic [CNT_W-1:0] DRV_START = CNT_W'(DRV_DLY);

  phase_e          phaseQ, phaseD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic [CNT_W-1:0] recovQ, recovD;
  strobe_t          strobeQ;
  logic             rspQ;

  // Read-enable level while writing: the variant picks it once.
  logic wrOeN;
  generate
    if (OE_LOW_WR) begin : g_oe_low
      assign wrOeN = 1'b0;
    end else begin : g_oe_high
      assign wrOeN = 1'b1;
    end
  endgenerate

  function automatic strobe_t decodeStrobes(input phase_e ph, input logic [CNT_W-1:0] cnt,
                                            input logic oeLevel);
    strobe_t s;
    s = '{ceN: 1'b1, weN: 1'b1, oeN: 1'b1, drive: 1'b0};
    case (ph)
      PH_READ: begin
        s.ceN = 1'b0;
        s.oeN = 1'b0;
      end
      PH_WSETUP: begin
        s.ceN = 1'b0;
        s.oeN = oeLevel;
      end
      PH_WPULSE: begin
        s.ceN   = 1'b0;
        s.weN   = 1'b0;
        s.oeN   = oeLevel;
        s.drive = (cnt >= DRV_START);
      end
      PH_WHOLD: begin
        s.ceN   = 1'b0;
        s.oeN   = oeLevel;
        s.drive = oeLevel;
      end
      default: ;
    endcase
    return s;
  endfunction

  assign reqReady = (phaseQ == PH_IDLE) && (recovQ == '0);
  assign accept   = reqValid && reqReady;

  always_comb begin
    phaseD  = phaseQ;
    cntD    = cntQ + 1'b1;
    recovD  = recovQ;
    capture = 1'b0;
    case (phaseQ)
      PH_IDLE: begin
        cntD = '0;
        if (recovQ != '0) recovD = recovQ - 1'b1;
        if (accept) phaseD = reqWrite ? PH_WSETUP : PH_READ;
      end
      PH_READ: begin
        if (cntQ == RD_LAST) begin
          capture = 1'b1;
          phaseD  = PH_IDLE;
          cntD    = '0;
          recovD  = RC_LOAD;
        end
      end
      PH_WSETUP: begin
        phaseD = PH_WPULSE;
        cntD   = '0;
      end
      PH_WPULSE: begin
        if (cntQ == WP_LAST) begin
          phaseD = PH_WHOLD;
          cntD   = '0;
        end
      end
      PH_WHOLD: begin
        if (cntQ == HOLD_LAST) begin
          phaseD = PH_IDLE;
          cntD   = '0;
          recovD = RC_LOAD;
        end
      end
      default: begin
        phaseD = PH_IDLE;
        cntD   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ  <= PH_IDLE;
      cntQ    <= '0;
      recovQ  <= RC_LOAD;
      strobeQ <= '{ceN: 1'b1, weN: 1'b1, oeN: 1'b1, drive: 1'b0};
      rspQ    <= 1'b0;
    end else begin
      phaseQ  <= phaseD;
      cntQ    <= cntD;
      recovQ  <= recovD;
      strobeQ <= decodeStrobes(phaseD, cntD, wrOeN);
      rspQ    <= capture;
    end
  end

  assign strobes  = strobeQ;
  assign rspValid = rspQ;

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              capture,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  // Address and write data are frozen for the whole access.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdataQ <= '0;
    else if (capture) rdataQ <= sramDqIn;
  end

  assign sramAddr  = addrQ;
  assign sramDqOut = wdataQ;
  assign sramDqOe  = strobes.drive;
  assign sramCeN   = strobes.ceN;
  assign sramWeN   = strobes.weN;
  assign sramOeN   = strobes.oeN;
  assign rspRdata  = rdataQ;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W         = 18,
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned CLK_PERIOD_PS  = 4000,
  parameter int unsigned T_RC_PS        = 10000,
  parameter int unsigned T_AA_PS        = 10000,
  parameter int unsigned T_OEACC_PS     = 4500,
  parameter int unsigned T_WC_PS        = 10000,
  parameter int unsigned T_AW_PS        = 8000,
  parameter int unsigned T_PW_OEHI_PS   = 8000,
  parameter int unsigned T_PW_OELO_PS   = 10000,
  parameter int unsigned T_DSU_PS       = 6000,
  parameter int unsigned T_WE_HIZ_PS    = 5000,
  parameter bit          OE_LOW_WR      = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int unsigned RD_CYC = max3(cyclesFor(T_RC_PS, CLK_PERIOD_PS),
                                        cyclesFor(T_AA_PS, CLK_PERIOD_PS),
                                        cyclesFor(T_OEACC_PS, CLK_PERIOD_PS));
  localparam int unsigned RC_CYC  = cyclesFor(T_RC_PS, CLK_PERIOD_PS);
  localparam int unsigned WC_CYC  = cyclesFor(T_WC_PS, CLK_PERIOD_PS);
  localparam int unsigned PW_CYC  = OE_LOW_WR ? cyclesFor(T_PW_OELO_PS, CLK_PERIOD_PS)
                                              : cyclesFor(T_PW_OEHI_PS, CLK_PERIOD_PS);
  localparam int unsigned DRV_DLY = OE_LOW_WR ? cyclesFor(T_WE_HIZ_PS, CLK_PERIOD_PS) : 0;
  localparam int unsigned WP_CYC  = max3(PW_CYC, cyclesFor(T_AW_PS, CLK_PERIOD_PS),
                                         DRV_DLY + cyclesFor(T_DSU_PS, CLK_PERIOD_PS));
  localparam int unsigned HOLD_CYC = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC - 1) : 1;
  localparam int unsigned CNT_W   = $clog2(max3(RD_CYC, WP_CYC, max2(HOLD_CYC, RC_CYC)) + 1);

  strobe_t strobes;
  logic    accept;
  logic    capture;

  // Derived windows, visible to the bound checker.
  logic [15:0] cfgWpCyc;
  logic [15:0] cfgRcCyc;
  assign cfgWpCyc = 16'(WP_CYC);
  assign cfgRcCyc = 16'(RC_CYC);

  sram_seq_ctrl #(
    .RD_CYC   (RD_CYC),
    .WP_CYC   (WP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .RC_CYC   (RC_CYC),
    .DRV_DLY  (DRV_DLY),
    .OE_LOW_WR(OE_LOW_WR),
    .CNT_W    (CNT_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .accept  (accept),
    .capture (capture),
    .rspValid(rspValid),
    .strobes (strobes)
  );

  sram_data_path #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .load     (accept),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .capture  (capture),
    .strobes  (strobes),
    .sramDqIn (sramDqIn),
    .sramAddr (sramAddr),
    .sramDqOut(sramDqOut),
    .sramDqOe (sramDqOe),
    .sramCeN  (sramCeN),
    .sramWeN  (sramWeN),
    .sramOeN  (sramOeN),
    .rspRdata (rspRdata)
  );

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sramCeN,
  input logic              sramWeN,
  input logic              sramOeN,
  input logic              sramDqOe,
  input logic [ADDR_W-1:0] sramAddr,
  input logic [DATA_W-1:0] sramDqOut,
  input logic              rspValid,
  input logic              reqReady,
  input logic [15:0]       cfgWpCyc,
  input logic [15:0]       cfgRcCyc
);

  logic [15:0] weLowCnt;
  logic [15:0] ceHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weLowCnt  <= '0;
      ceHighCnt <= '0;
    end else begin
      if (sramWeN) weLowCnt <= '0;
      else if (weLowCnt != 16'hFFFF) weLowCnt <= weLowCnt + 1'b1;
      if (!sramCeN) ceHighCnt <= '0;
      else if (ceHighCnt != 16'hFFFF) ceHighCnt <= ceHighCnt + 1'b1;
    end
  end

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    sramCeN |-> (!sramDqOe && sramWeN && sramOeN));

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> (!sramCeN && (sramOeN || !sramWeN)));

  // R6
  drive_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramDqOe) |-> ($past(sramOeN) || !$past(sramWeN)));

  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && !$past(sramCeN)) |-> $stable(sramAddr));

  // R7
  data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sramDqOe && $past(sramDqOe)) |-> $stable(sramDqOut));

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R4
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(!sramCeN) && $past(!sramOeN) && $past(sramWeN) && sramCeN));

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> sramCeN);

  // R5
  we_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> !sramCeN);

  // R5
  we_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWeN) |-> $past(!sramCeN));

  // R5
  we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (weLowCnt == cfgWpCyc));

  // R9
  recovery_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramCeN) |-> (ceHighCnt >= cfgRcCyc));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .sramCeN  (sramCeN),
  .sramWeN  (sramWeN),
  .sramOeN  (sramOeN),
  .sramDqOe (sramDqOe),
  .sramAddr (sramAddr),
  .sramDqOut(sramDqOut),
  .rspValid (rspValid),
  .reqReady (reqReady),
  .cfgWpCyc (cfgWpCyc),
  .cfgRcCyc (cfgRcCyc)
);

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb_top;

  localparam int P_PS    = 4000;
  localparam int EXP_RD  = (10000 + P_PS - 1) / P_PS;
  localparam int EXP_RC  = (10000 + P_PS - 1) / P_PS;
  localparam int EXP_WC  = (10000 + P_PS - 1) / P_PS;
  localparam int PW_A    = (8000 + P_PS - 1) / P_PS;
  localparam int PW_B    = (6000 + P_PS - 1) / P_PS;
  localparam int EXP_WP  = (PW_A > PW_B) ? PW_A : PW_B;
  localparam int EXP_HLD = (EXP_WC > EXP_WP + 1) ? EXP_WC - EXP_WP - 1 : 1;
  localparam int EXP_WLEN = 1 + EXP_WP + EXP_HLD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic reqReady, rspValid;
  logic [7:0] rspRdata;
  logic [17:0] sramAddr;
  logic sramCeN, sramWeN, sramOeN, sramDqOe;
  logic [7:0] sramDqOut;
  logic [7:0] sramDqIn = 8'hEE;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2ns clk = ~clk;

  sram_strobe_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .sramAddr(sramAddr),
    .sramCeN(sramCeN), .sramWeN(sramWeN), .sramOeN(sramOeN),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Memory model and per-cycle monitor, sampled at the falling edge.
  logic [7:0] mem [int unsigned];
  bit pWeLow = 0, pDrive = 0, pCeN = 1, pOeN = 1, pWeN = 1, sawWe = 0;
  logic [17:0] pAddr = '0, accAddr = '0;
  logic [7:0] pData = '0;
  int ceLow = 0, ceHigh = 0, weLow = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      pWeLow = 0; pCeN = 1; pOeN = 1; pWeN = 1; ceHigh = 0; ceLow = 0; weLow = 0;
    end else begin
      if (pWeLow && sramWeN) begin
        // R8: data driven in the last cycle of the write pulse
        check(pDrive, "R8 drive at write end", pDrive, 1);
        // R5: write pulse length
        check(weLow == EXP_WP, "R5 write pulse cycles", weLow, EXP_WP);
        mem[32'(pAddr)] = pData;
        weLow = 0;
      end
      // R6: no driving into a reading memory, start only after read-enable high
      if (sramDqOe && (sramCeN || (!sramOeN && sramWeN)))
        check(0, "R6 bus contention", 1, 0);
      if (sramDqOe && !pDrive && !(pOeN || !pWeN))
        check(0, "R6 drive before read-enable high", 0, 1);
      // R2: released while deselected
      if (sramCeN && (!sramWeN || !sramOeN || sramDqOe))
        check(0, "R2 strobes while deselected", 0, 1);
      if (!sramCeN) begin
        if (pCeN) begin
          // R9: recovery gap
          check(ceHigh >= EXP_RC, "R9 deselect gap", ceHigh, EXP_RC);
          accAddr = sramAddr; ceLow = 0; sawWe = 0;
          // R5: write starts with a setup cycle
          if (!sramOeN == 0 && !sramWeN) check(0, "R5 no setup cycle", 0, 1);
        end
        ceLow++;
        if (!sramWeN) begin sawWe = 1; weLow++; end
        if (sramAddr != accAddr) check(0, "R7 address moved", int'(sramAddr), int'(accAddr));
        if (reqReady) check(0, "R10 ready while busy", 1, 0);
      end else if (!pCeN) begin
        // R3 / R8: select window length
        if (sawWe) check(ceLow == EXP_WLEN, "R8 write select cycles", ceLow, EXP_WLEN);
        else check(ceLow == EXP_RD, "R3 read select cycles", ceLow, EXP_RD);
        ceHigh = 1;
      end else ceHigh++;
      sramDqIn = (!sramCeN && !sramOeN && sramWeN)
                 ? (mem.exists(32'(sramAddr)) ? mem[32'(sramAddr)] : 8'h00) : 8'hEE;
      pWeLow = !sramWeN; pDrive = sramDqOe; pAddr = sramAddr; pData = sramDqOut;
      pCeN = sramCeN; pOeN = sramOeN; pWeN = sramWeN;
    end
  end

  function automatic logic [7:0] pattern(input logic [17:0] a);
    return a[7:0] + 8'(a[15:8] * 3) + 8'(a[17:16] * 7) + 8'h3C;
  endfunction

  task automatic doAccess(input bit wr, input logic [17:0] a, input logic [7:0] d,
                          input logic [7:0] expRead);
    int k;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0; reqAddr = ~a; reqWdata = ~d;
    k = 1;
    if (!wr) begin
      while (!rspValid && k < 50) begin @(negedge clk); k++; end
      check(k == EXP_RD + 1, "R4 response latency", k, EXP_RD + 1);
      check(rspRdata == expRead, "R7 read-back data", rspRdata, expRead);
      @(negedge clk); k++;
      check(!rspValid, "R4 single-cycle response", rspValid, 0);
      while (!reqReady && k < 60) begin @(negedge clk); k++; end
      check(k == EXP_RD + EXP_RC + 1, "R10 ready after read", k, EXP_RD + EXP_RC + 1);
    end else begin
      while (!reqReady && k < 60) begin @(negedge clk); k++; end
      check(k == EXP_WLEN + EXP_RC + 1, "R10 ready after write", k, EXP_WLEN + EXP_RC + 1);
    end
  endtask

  logic [17:0] addrList [$];

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sramCeN && sramWeN && sramOeN, "R1 strobes in reset", {sramCeN, sramWeN, sramOeN}, 7);
    check(!sramDqOe && !rspValid && !reqReady, "R1 outputs in reset",
          {sramDqOe, rspValid, reqReady}, 0);
    rstN = 1;
    k = 0;
    @(negedge clk); k++;
    check(sramCeN && !sramDqOe && !reqReady, "R1 first cycle after reset",
          {sramCeN, sramDqOe, reqReady}, 4);
    while (!reqReady && k < 20) begin @(negedge clk); k++; end
    check(k == EXP_RC, "R1 ready after reset", k, EXP_RC);

    // R7: address sweep, all writes first, then all reads
    for (int i = 0; i < 256; i++) addrList.push_back(18'(i));
    for (int b = 8; b < 18; b++) addrList.push_back(18'(1) << b);
    addrList.push_back(18'h3FFFF);
    addrList.push_back(18'h2AAAA);
    foreach (addrList[i]) doAccess(1, addrList[i], pattern(addrList[i]), 8'h00);
    foreach (addrList[i]) doAccess(0, addrList[i], 8'h00, pattern(addrList[i]));

    // R7: every data value at one address
    for (int v = 0; v < 256; v++) begin
      doAccess(1, 18'h15555, 8'(v), 8'h00);
      doAccess(0, 18'h15555, 8'h00, 8'(v));
    end

    // R10: request held valid during a read is taken only when ready returns
    reqValid = 1; reqWrite = 0; reqAddr = 18'h00042;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqWrite = 1; reqAddr = 18'h00777; reqWdata = 8'hC3;
    k = 1;
    while (!reqReady && k < 60) begin
      if (rspValid) check(rspRdata == pattern(18'h00042), "R4 read data under held request",
                          rspRdata, pattern(18'h00042));
      @(negedge clk); k++;
    end
    check(k == EXP_RD + EXP_RC + 1, "R10 held request waits", k, EXP_RD + EXP_RC + 1);
    @(negedge clk);
    reqValid = 0;
    k = 1;
    while (!reqReady && k < 60) begin @(negedge clk); k++; end
    check(k == EXP_WLEN + EXP_RC + 1, "R10 held write completes", k, EXP_WLEN + EXP_RC + 1);
    doAccess(0, 18'h00777, 8'h00, 8'hC3);
    doAccess(0, 18'h00042, 8'h00, pattern(18'h00042));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule